// File: doc/BRIEF.md
# Time Calendar Update Engine

This block keeps the running time of day and the calendar. It steps forward by one second each time a one-second strobe arrives. Software sees ten byte registers through a small register port: the time and calendar fields plus three alarm bytes.

Every byte is encoded either as plain binary or as packed BCD. The hours byte follows either a 24-hour format or a 12-hour format that carries a PM flag. Inside the block the count is held in binary form. A separate user-visible copy is encoded for reads.

While the freeze input is high, the user copy holds still so software can write a new time without a tick breaking in. The running count keeps counting during the freeze. When the freeze is released, the user copy becomes the running count. An optional daylight-saving rule moves the hour forward one Sunday each April and back one Sunday each October. After each step the block emits a one-cycle update pulse. It also emits a one-cycle alarm pulse when seconds, minutes and hours match the alarm bytes, where any alarm byte may be a wildcard.

Top module: `rtc_cal_core`

## Requirements
- R1: The count wraps seconds and minutes at 60 and hours at 24. Date runs 1 to the month length: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for month 2 when the year value is divisible by 4 (28 otherwise). Month runs 1 to 12.
- R2: With bin_mode_i=1 all bytes read as plain binary (59 seconds = 8'h3B). With bin_mode_i=0 all bytes read as packed BCD, tens in bits 7:4 and units in bits 3:0 (59 = 8'h59).
- R3: With hr24_i=1 the hours byte holds 0-23. With hr24_i=0 it holds 1-12 in bits 6:0 and bit 7 set for PM. Midnight reads as 12 AM and noon as 12 PM, so 11:59:59 PM steps to 8'h12 and 11:59:59 AM steps to 8'h92 in BCD.
- R4: While set_i is 1 the user copy read at addresses 0,2,4,6,7,8,9 does not change on ticks. The running count still advances and still drives the update and alarm outputs.
- R5: In the cycle after set_i falls, the user copy is loaded into the running count. Later ticks advance from the written value.
- R6: Alarm bytes sit at address 1 (seconds), 3 (minutes) and 5 (hours). An alarm byte with bits 7:6 both 1 matches any value. alarm_o pulses for one cycle, in the cycle after a tick, when the new time matches all three bytes.
- R7: update_o is 1 in exactly the cycle after each cycle in which tick_i is 1, and 0 otherwise.
- R8: With dst_en_i=1, on a Sunday (day-of-week 1) in month 4 with date 1 to 7, a tick at 1:59:59 gives 3:00:00. On other dates, or with dst_en_i=0, it gives 2:00:00.
- R9: With dst_en_i=1, on a Sunday in month 10 with date 25 or later, the first tick at 1:59:59 gives 1:00:00. A second arrival at 1:59:59 that day steps normally to 2:00:00.
- R10: Bit 7 of the seconds byte (address 0) always reads 0, whatever is written.
- R11: After reset the time reads 00:00:00, day-of-week 1, date 1, month 1, year 0, and both pulses are 0.
- R12: Day-of-week wraps from 7 to 1 at midnight, and year wraps from YEAR_MOD-1 to 0 when December 31 rolls over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| set_i | input | 1 | Freeze the user copy for writing |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en_i | input | 1 | Enable the daylight-saving steps |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address, 0 to 9 used |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (0 above 9) |
| alarm_o | output | 1 | Alarm match pulse |
| update_o | output | 1 | Update-ended pulse |

## Verification
The bench builds the block with its default YEAR_MOD of 100. This puts the year wrap from 99 to 0 one tick away from a loaded December 31 at 23:59:59, and the same tick also shows the day-of-week and month wraps. Times are loaded through the freeze sequence, which reaches every month-length, leap-year, 12-hour and daylight-saving corner in one or two ticks. The alarm pulse during a freeze is how the bench observes that the hidden running count keeps advancing.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int REG_COUNT = 10;

    localparam logic [3:0] A_SEC     = 4'd0;
    localparam logic [3:0] A_SEC_ALM = 4'd1;
    localparam logic [3:0] A_MIN     = 4'd2;
    localparam logic [3:0] A_MIN_ALM = 4'd3;
    localparam logic [3:0] A_HOUR    = 4'd4;
    localparam logic [3:0] A_HR_ALM  = 4'd5;
    localparam logic [3:0] A_DOW     = 4'd6;
    localparam logic [3:0] A_DATE    = 4'd7;
    localparam logic [3:0] A_MONTH   = 4'd8;
    localparam logic [3:0] A_YEAR    = 4'd9;

    localparam logic [2:0] DOW_SUNDAY = 3'd1;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] month;
        logic [6:0] year;
    } cal_t;

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [7:0] t8;
        logic [7:0] u8;
        t8 = 8'(v) / 8'd10;
        u8 = 8'(v) - t8 * 8'd10;
        return bin ? 8'(v) : ((t8 << 4) | u8);
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic hr24);
        logic [4:0] h12;
        logic [7:0] e;
        if (hr24) begin
            return enc_val(7'(h), bin);
        end
        h12 = (h == 5'd0) ? 5'd12 : ((h > 5'd12) ? h - 5'd12 : h);
        e   = enc_val(7'(h12), bin);
        return {h >= 5'd12, 7'(e)};
    endfunction

    function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic hr24);
        logic [4:0] v;
        if (hr24) begin
            return 5'(dec_val(b, bin));
        end
        v = 5'(dec_val({1'b0, b[6:0]}, bin));
        if (v == 5'd12) v = 5'd0;
        return b[7] ? v + 5'd12 : v;
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_MOD = 100
) (
    input  cal_t cur_i,
    input  logic dst_en_i,
    input  logic fell_back_i,
    output cal_t nxt_o,
    output logic fell_back_o
);
    localparam logic [6:0] YEAR_LAST = 7'(YEAR_MOD - 1);

    logic       end_min;
    logic       at_159;
    logic       spring;
    logic       fall;
    logic       day_roll;
    logic [4:0] mlen;

    always_comb begin
        nxt_o       = cur_i;
        fell_back_o = fell_back_i;
        end_min  = (cur_i.sec == 7'd59) && (cur_i.min == 7'd59);
        at_159   = dst_en_i && end_min && (cur_i.hour == 5'd1) && (cur_i.dow == DOW_SUNDAY);
        spring   = at_159 && (cur_i.month == 4'd4) && (cur_i.date <= 5'd7);
        fall     = at_159 && (cur_i.month == 4'd10) && (cur_i.date >= 5'd25) && !fell_back_i;
        day_roll = end_min && (cur_i.hour == 5'd23);
        mlen     = month_len(cur_i.month, cur_i.year[1:0] == 2'd0);

        nxt_o.sec = (cur_i.sec == 7'd59) ? 7'd0 : cur_i.sec + 7'd1;
        if (cur_i.sec == 7'd59) begin
            nxt_o.min = (cur_i.min == 7'd59) ? 7'd0 : cur_i.min + 7'd1;
        end
        if (end_min) begin
            if (spring) begin
                nxt_o.hour = 5'd3;
            end else if (fall) begin
                nxt_o.hour  = 5'd1;
                fell_back_o = 1'b1;
            end else if (day_roll) begin
                nxt_o.hour = 5'd0;
            end else begin
                nxt_o.hour = cur_i.hour + 5'd1;
            end
        end
        if (day_roll) begin
            fell_back_o = 1'b0;
            nxt_o.dow   = (cur_i.dow == 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
            if (cur_i.date >= mlen) begin
                nxt_o.date = 5'd1;
                if (cur_i.month >= 4'd12) begin
                    nxt_o.month = 4'd1;
                    nxt_o.year  = (cur_i.year >= YEAR_LAST) ? 7'd0 : cur_i.year + 7'd1;
                end else begin
                    nxt_o.month = cur_i.month + 4'd1;
                end
            end else begin
                nxt_o.date = cur_i.date + 5'd1;
            end
        end
    end
endmodule

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode
    import rtc_cal_pkg::*;
(
    input  cal_t             cal_i,
    input  logic             bin_i,
    input  logic             hr24_i,
    output logic [6:0][7:0]  bytes_o
);
    always_comb begin
        bytes_o[0] = enc_val(cal_i.sec, bin_i);
        bytes_o[1] = enc_val(cal_i.min, bin_i);
        bytes_o[2] = enc_hour(cal_i.hour, bin_i, hr24_i);
        bytes_o[3] = enc_val(7'(cal_i.dow), bin_i);
        bytes_o[4] = enc_val(7'(cal_i.date), bin_i);
        bytes_o[5] = enc_val(7'(cal_i.month), bin_i);
        bytes_o[6] = enc_val(cal_i.year, bin_i);
    end
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm #(
    parameter int LANES = 3
) (
    input  logic [LANES-1:0][7:0] now_i,
    input  logic [LANES-1:0][7:0] alm_i,
    output logic                  hit_o
);
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (alm_i[g][7:6] == 2'b11) || (alm_i[g] == now_i[g]);
    end

    assign hit_o = &lane_hit;
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_MOD = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       set_i,
    input  logic       bin_mode_i,
    input  logic       hr24_i,
    input  logic       dst_en_i,
    input  logic       wr_en_i,
    input  logic [3:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       alarm_o,
    output logic       update_o
);
    typedef struct packed {
        cal_t                        cal;
        logic                        fell_back;
        logic                        set_prev;
        logic                        alarm;
        logic                        upd;
        logic [REG_COUNT-1:0][7:0]   regs;
    } state_t;

    state_t          s_q, s_d;
    logic            load;
    cal_t            base;
    logic            fb_base;
    cal_t            adv_cal;
    logic            adv_fb;
    cal_t            cal_nx;
    logic            fb_nx;
    logic [6:0][7:0] enc;
    logic            match;

    // Front end: pick the starting point of this cycle's count
    always_comb begin
        load    = s_q.set_prev && !set_i;
        base    = s_q.cal;
        fb_base = s_q.fell_back;
        if (load) begin
            base.sec   = dec_val({1'b0, s_q.regs[A_SEC][6:0]}, bin_mode_i);
            base.min   = dec_val(s_q.regs[A_MIN], bin_mode_i);
            base.hour  = dec_hour(s_q.regs[A_HOUR], bin_mode_i, hr24_i);
            base.dow   = 3'(dec_val(s_q.regs[A_DOW], bin_mode_i));
            base.date  = 5'(dec_val(s_q.regs[A_DATE], bin_mode_i));
            base.month = 4'(dec_val(s_q.regs[A_MONTH], bin_mode_i));
            base.year  = dec_val(s_q.regs[A_YEAR], bin_mode_i);
            fb_base    = 1'b0;
        end
        if (wr_en_i && !set_i) begin
            case (addr_i)
                A_SEC:   base.sec   = dec_val({1'b0, wdata_i[6:0]}, bin_mode_i);
                A_MIN:   base.min   = dec_val(wdata_i, bin_mode_i);
                A_HOUR:  base.hour  = dec_hour(wdata_i, bin_mode_i, hr24_i);
                A_DOW:   base.dow   = 3'(dec_val(wdata_i, bin_mode_i));
                A_DATE:  base.date  = 5'(dec_val(wdata_i, bin_mode_i));
                A_MONTH: base.month = 4'(dec_val(wdata_i, bin_mode_i));
                A_YEAR:  base.year  = dec_val(wdata_i, bin_mode_i);
                default: ;
            endcase
        end
    end

    rtc_cal_advance #(.YEAR_MOD(YEAR_MOD)) u_adv (
        .cur_i       (base),
        .dst_en_i    (dst_en_i),
        .fell_back_i (fb_base),
        .nxt_o       (adv_cal),
        .fell_back_o (adv_fb)
    );

    assign cal_nx = tick_i ? adv_cal : base;
    assign fb_nx  = tick_i ? adv_fb  : fb_base;

    rtc_cal_encode u_enc (
        .cal_i   (cal_nx),
        .bin_i   (bin_mode_i),
        .hr24_i  (hr24_i),
        .bytes_o (enc)
    );

    rtc_cal_alarm #(.LANES(3)) u_alm (
        .now_i ({enc[2], enc[1], enc[0]}),
        .alm_i ({s_q.regs[A_HR_ALM], s_q.regs[A_MIN_ALM], s_q.regs[A_SEC_ALM]}),
        .hit_o (match)
    );

    always_comb begin
        s_d           = s_q;
        s_d.cal       = cal_nx;
        s_d.fell_back = fb_nx;
        s_d.set_prev  = set_i;
        s_d.upd       = tick_i;
        s_d.alarm     = tick_i && match;
        if (!set_i) begin
            s_d.regs[A_SEC]   = enc[0];
            s_d.regs[A_MIN]   = enc[1];
            s_d.regs[A_HOUR]  = enc[2];
            s_d.regs[A_DOW]   = enc[3];
            s_d.regs[A_DATE]  = enc[4];
            s_d.regs[A_MONTH] = enc[5];
            s_d.regs[A_YEAR]  = enc[6];
        end
        if (wr_en_i) begin
            case (addr_i)
                A_SEC_ALM, A_MIN_ALM, A_HR_ALM: s_d.regs[addr_i] = wdata_i;
                A_SEC: if (set_i) s_d.regs[A_SEC] = {1'b0, wdata_i[6:0]};
                A_MIN, A_HOUR, A_DOW, A_DATE, A_MONTH, A_YEAR:
                    if (set_i) s_d.regs[addr_i] = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q                 <= '0;
            s_q.cal.dow         <= 3'd1;
            s_q.cal.date        <= 5'd1;
            s_q.cal.month       <= 4'd1;
            s_q.regs[A_DOW]     <= 8'h01;
            s_q.regs[A_DATE]    <= 8'h01;
            s_q.regs[A_MONTH]   <= 8'h01;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (addr_i == 4'(i)) rdata_o = s_q.regs[i];
        end
    end

    assign alarm_o  = s_q.alarm;
    assign update_o = s_q.upd;
endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       set_i,
    input logic       wr_en_i,
    input logic       alarm_o,
    input logic       update_o,
    input logic [6:0] sec_q,
    input logic [6:0] min_q,
    input logic [4:0] hour_q,
    input logic [79:0] regs_q
);
    AST_TICK_GIVES_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> update_o);  // R7
    AST_NO_UPDATE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !update_o);  // R7
    AST_ALARM_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> update_o);  // R6
    AST_TIME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q < 7'd60) && (min_q < 7'd60) && (hour_q < 5'd24));  // R1
    AST_FROZEN_USER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !wr_en_i) |=> $stable(regs_q));  // R4
    AST_SEC_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q[7]);  // R10
endmodule

bind rtc_cal_core rtc_cal_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .set_i    (set_i),
    .wr_en_i  (wr_en_i),
    .alarm_o  (alarm_o),
    .update_o (update_o),
    .sec_q    (s_q.cal.sec),
    .min_q    (s_q.cal.min),
    .hour_q   (s_q.cal.hour),
    .regs_q   (s_q.regs)
);

// File: tb/rtc_cal_core_tb_top.sv
module rtc_cal_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       set = 1'b0;
    logic       bin = 1'b0;
    logic       hr24 = 1'b1;
    logic       dst = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       alarm;
    logic       upd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rtc_cal_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .set_i(set),
        .bin_mode_i(bin), .hr24_i(hr24), .dst_en_i(dst),
        .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .alarm_o(alarm), .update_o(upd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_tick(output logic u, output logic al);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        u = upd;
        al = alarm;
    endtask

    task automatic load_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
        @(negedge clk);
        set = 1'b1;
        wr_byte(4'd0, s);  wr_byte(4'd2, m);  wr_byte(4'd4, h);
        wr_byte(4'd6, dw); wr_byte(4'd7, dt); wr_byte(4'd8, mo);
        wr_byte(4'd9, yr);
        @(negedge clk);
        set = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 update", {7'd0, upd}, 8'h00);
        chk("R11 alarm", {7'd0, alarm}, 8'h00);
        rd_chk("R11 sec", 4'd0, 8'h00);
        rd_chk("R11 min", 4'd2, 8'h00);
        rd_chk("R11 hour", 4'd4, 8'h00);
        rd_chk("R11 dow", 4'd6, 8'h01);
        rd_chk("R11 date", 4'd7, 8'h01);
        rd_chk("R11 month", 4'd8, 8'h01);
        rd_chk("R11 year", 4'd9, 8'h00);
    endtask

    task automatic t_year_end();
        logic u, al;
        wr_byte(4'd1, 8'h7F);
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick(u, al);
        chk("R7 update pulse", {7'd0, u}, 8'h01);
        @(negedge clk);
        chk("R7 pulse one cycle", {7'd0, upd}, 8'h00);
        rd_chk("R1 sec wrap", 4'd0, 8'h00);
        rd_chk("R1 min wrap", 4'd2, 8'h00);
        rd_chk("R1 hour wrap", 4'd4, 8'h00);
        rd_chk("R12 dow wrap", 4'd6, 8'h01);
        rd_chk("R1 date wrap", 4'd7, 8'h01);
        rd_chk("R1 month wrap", 4'd8, 8'h01);
        rd_chk("R12 year wrap", 4'd9, 8'h00);
    endtask

    task automatic t_leap();
        logic u, al;
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick(u, al);
        rd_chk("R1 leap date", 4'd7, 8'h29);
        rd_chk("R1 leap month", 4'd8, 8'h02);
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        do_tick(u, al);
        rd_chk("R1 nonleap date", 4'd7, 8'h01);
        rd_chk("R1 nonleap month", 4'd8, 8'h03);
    endtask

    task automatic t_binary();
        logic u, al;
        @(negedge clk); bin = 1'b1;
        load_time(8'h3B, 8'h3A, 8'h17, 8'h03, 8'h1E, 8'h04, 8'h05);
        do_tick(u, al);
        rd_chk("R2 bin min", 4'd2, 8'h3B);
        rd_chk("R2 bin sec", 4'd0, 8'h00);
        load_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1E, 8'h04, 8'h05);
        do_tick(u, al);
        rd_chk("R2 bin hour", 4'd4, 8'h00);
        rd_chk("R2 bin dow", 4'd6, 8'h04);
        rd_chk("R1 april 30 date", 4'd7, 8'h01);
        rd_chk("R1 april 30 month", 4'd8, 8'h05);
        @(negedge clk); bin = 1'b0;
    endtask

    task automatic t_twelve();
        logic u, al;
        @(negedge clk); hr24 = 1'b0;
        load_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h06, 8'h20);
        do_tick(u, al);
        rd_chk("R3 midnight 12AM", 4'd4, 8'h12);
        rd_chk("R3 day rolls", 4'd7, 8'h11);
        load_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h06, 8'h20);
        do_tick(u, al);
        rd_chk("R3 noon 12PM", 4'd4, 8'h92);
        @(negedge clk); hr24 = 1'b1;
    endtask

    task automatic t_alarm();
        logic u, al;
        load_time(8'h07, 8'h06, 8'h05, 8'h02, 8'h10, 8'h06, 8'h20);
        wr_byte(4'd1, 8'h08); wr_byte(4'd3, 8'h06); wr_byte(4'd5, 8'h05);
        do_tick(u, al);
        chk("R6 exact match", {7'd0, al}, 8'h01);
        @(negedge clk);
        chk("R6 pulse one cycle", {7'd0, alarm}, 8'h00);
        do_tick(u, al);
        chk("R6 no match", {7'd0, al}, 8'h00);
        wr_byte(4'd5, 8'hC0); wr_byte(4'd3, 8'hFF); wr_byte(4'd1, 8'h10);
        do_tick(u, al);
        chk("R6 wildcard match", {7'd0, al}, 8'h01);
        wr_byte(4'd1, 8'h7F);
    endtask

    task automatic t_freeze();
        logic u, al;
        load_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h06, 8'h20);
        wr_byte(4'd1, 8'h33); wr_byte(4'd3, 8'hC0); wr_byte(4'd5, 8'hC0);
        @(negedge clk); set = 1'b1;
        do_tick(u, al);
        do_tick(u, al);
        do_tick(u, al);
        chk("R4 running count alarms", {7'd0, al}, 8'h01);
        chk("R4 update during freeze", {7'd0, u}, 8'h01);
        rd_chk("R4 frozen sec", 4'd0, 8'h30);
        wr_byte(4'd1, 8'h7F);
        wr_byte(4'd0, 8'hD5);
        rd_chk("R10 sec msb read-only", 4'd0, 8'h55);
        wr_byte(4'd0, 8'h45);
        do_tick(u, al);
        @(negedge clk); set = 1'b0;
        @(negedge clk);
        rd_chk("R5 loaded sec", 4'd0, 8'h45);
        rd_chk("R5 loaded min", 4'd2, 8'h20);
        do_tick(u, al);
        rd_chk("R5 advances from load", 4'd0, 8'h46);
    endtask

    task automatic t_dst();
        logic u, al;
        @(negedge clk); dst = 1'b1;
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h24);
        do_tick(u, al);
        rd_chk("R8 spring hour", 4'd4, 8'h03);
        rd_chk("R8 spring min", 4'd2, 8'h00);
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h08, 8'h04, 8'h24);
        do_tick(u, al);
        rd_chk("R8 second Sunday normal", 4'd4, 8'h02);
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h24);
        do_tick(u, al);
        rd_chk("R9 fall back hour", 4'd4, 8'h01);
        rd_chk("R9 fall back sec", 4'd0, 8'h00);
        wr_byte(4'd2, 8'h59);
        wr_byte(4'd0, 8'h59);
        do_tick(u, al);
        rd_chk("R9 only once", 4'd4, 8'h02);
        @(negedge clk); dst = 1'b0;
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h24);
        do_tick(u, al);
        rd_chk("R8 disabled", 4'd4, 8'h02);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_year_end();
        t_leap();
        t_binary();
        t_twelve();
        t_alarm();
        t_freeze();
        t_dst();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        report();
    end
endmodule